// File: doc/BRIEF.md
# Machine State Register Update Unit

This block holds the 64-bit machine state word of a processor thread (bit 0 is the least significant bit). It changes that word for three kinds of operation. The first is a return from an interrupt, in a supervisor form and a hypervisor form. It reloads the word from a saved-state register and hands back a resume address. The second is a move from a general register, full or partial, in a 64-bit and a 32-bit form. The third is a plain read. Fields are not copied blindly. Some bits are guarded against being set again, some are forced on when source bit 14 is set, and the three-bit transaction field at bits 34:32 refuses one specific transition.

The operation is presented for one cycle with `op_valid`. The word changes on the clock edge that samples the strobe. `op_code` selects the operation: 0 = read, 1 = supervisor return, 2 = hypervisor return, 3 = 64-bit move, 4 = 32-bit move, and 5 to 7 are reserved. `l_flag` selects the partial form of a move. `priv_mode` is high while the issuing thread runs privileged.

Top module: `mstate_update_unit`

## Requirements
- R1: A synchronous active-high reset clears `state_out` to zero and holds `addr_valid` and `priv_fault` low.
- R2: On a supervisor return, new bit 60 = old bit 60 AND saved bit 60. New bit 12 = saved bit 12 when old bit 60 is one, and the old bit 12 otherwise.
- R3: For a return of either kind and for a 64-bit move with `l_flag`=0, bits 34:32 take the source value. The one exception is a current value of 3'b010 with a source value of 3'b000, where the field keeps 3'b010.
- R4: When source bit 14 is one, a return and a 32-bit move force bits 15, 5 and 4 on, and a 64-bit move forces bits 5 and 4 on. Otherwise each of those bits takes its own source bit.
- R5: A supervisor return copies bits 63:61, 59:35, 31, 26:22, 14:13, 11:6 and 3:0 from `sup_saved_state`. Bits 30:27 and 21:16 keep their old value.
- R6: A hypervisor return reads `hyp_saved_state` and `hyp_saved_addr`. It copies bits 63:35, 31, 26:22, 14:6 and 3:0, with no guard on bits 60 and 12. It never faults, whatever `priv_mode` is.
- R7: A completed return raises `addr_valid` for exactly the one cycle after the strobe. In that cycle `next_addr` equals the chosen saved address with bits 1:0 cleared.
- R8: A 64-bit move with `l_flag`=0 copies bits 63:61, 59:35, 31:16, 14:13, 11:6 and 3:1 from `gpr_src`. Bits 60, 15, 12 and 0 keep their value.
- R9: A 32-bit move with `l_flag`=0 copies bits 31:16, 14:13, 11:6 and 3:1. Bits 63:32, 12 and 0 keep their value.
- R10: A move of either width with `l_flag`=1 changes only bits 15 and 1, which take the source bits.
- R11: A supervisor return or a move issued with `priv_mode` low raises `priv_fault` for one cycle. It leaves `state_out` unchanged and keeps `addr_valid` low.
- R12: A read or a reserved code leaves `state_out` unchanged and raises neither `addr_valid` nor `priv_fault`.
- R13: `state_out` changes only on the edge that samples `op_valid` high. With no strobe it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Operation select |
| l_flag | input | 1 | Partial-move select |
| gpr_src | input | 64 | General register source for moves |
| sup_saved_state | input | 64 | Supervisor saved state word |
| sup_saved_addr | input | 64 | Supervisor saved resume address |
| hyp_saved_state | input | 64 | Hypervisor saved state word |
| hyp_saved_addr | input | 64 | Hypervisor saved resume address |
| priv_mode | input | 1 | Issuing thread is privileged |
| state_out | output | 64 | Current machine state word |
| next_addr | output | 64 | Resume address after a return |
| addr_valid | output | 1 | `next_addr` valid, one cycle |
| priv_fault | output | 1 | Privilege violation, one cycle |

## Verification
The stored word is the only state, and it is visible on `state_out` one cycle after every strobe. A wrong guard on bit 60 or on the transaction field therefore shows at the ports on the very next operation. Such an error is not recoverable: a bit 60 that was set again wrongly, or a field that left 3'b010, colours every later return. The bench keeps its own shadow word and compares after each operation, so a divergence is reported at the first operation that exposes it. Chained sequences are needed to make the guards observable: set bit 60, return, then return again.

// File: rtl/msu_pkg.sv
package msu_pkg;

   typedef enum logic [2:0] {
      OP_READ    = 3'd0,
      OP_RET_SUP = 3'd1,
      OP_RET_HYP = 3'd2,
      OP_MOVE64  = 3'd3,
      OP_MOVE32  = 3'd4
   } msu_op_e;

   localparam int unsigned WORD_W  = 64;
   localparam int unsigned TS_HI   = 34;
   localparam int unsigned TS_LO   = 32;
   localparam int unsigned GUARD   = 14;
   localparam logic [2:0]  TS_HOLD = 3'b010;

   // contiguous mask of ones from bit lo up to bit hi
   function automatic logic [WORD_W-1:0] span(input int unsigned hi, input int unsigned lo);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int unsigned i = lo; i <= hi; i++) m[i] = 1'b1;
      return m;
   endfunction

   // transaction field selection: a held 010 refuses a 000 source
   function automatic logic [2:0] ts_pick(input logic [2:0] cur, input logic [2:0] src);
      return ((cur == TS_HOLD) && (src == 3'b000)) ? cur : src;
   endfunction

endpackage

// File: rtl/msu_return_calc.sv
module msu_return_calc
   import msu_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned ALIGN_BITS = 2,
   parameter bit          HYPER      = 1'b0
) (
   input  logic [XLEN-1:0] old_state,
   input  logic [XLEN-1:0] saved_state,
   input  logic [XLEN-1:0] saved_addr,
   output logic [XLEN-1:0] new_state,
   output logic [XLEN-1:0] new_addr
);
   localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);
   localparam logic [XLEN-1:0] SUP_COPY =
      span(63, 61) | span(59, 35) | span(31, 31) | span(26, 22) |
      span(14, 13) | span(11, 6)  | span(3, 0);
   localparam logic [XLEN-1:0] HYP_COPY =
      span(63, 35) | span(31, 31) | span(26, 22) | span(14, 6) | span(3, 0);

   logic [XLEN-1:0] merged;

   assign new_addr = saved_addr & ~ALIGN_MASK;

   generate
      if (HYPER) begin : g_hyp
         always_comb begin
            merged = (saved_state & HYP_COPY) | (old_state & ~HYP_COPY);
            merged[TS_HI:TS_LO] = ts_pick(old_state[TS_HI:TS_LO], saved_state[TS_HI:TS_LO]);
            merged[15] = saved_state[15] | saved_state[GUARD];
            merged[5]  = saved_state[5]  | saved_state[GUARD];
            merged[4]  = saved_state[4]  | saved_state[GUARD];
         end
      end else begin : g_sup
         always_comb begin
            merged = (saved_state & SUP_COPY) | (old_state & ~SUP_COPY);
            merged[TS_HI:TS_LO] = ts_pick(old_state[TS_HI:TS_LO], saved_state[TS_HI:TS_LO]);
            merged[15] = saved_state[15] | saved_state[GUARD];
            merged[5]  = saved_state[5]  | saved_state[GUARD];
            merged[4]  = saved_state[4]  | saved_state[GUARD];
            // guarded bits: 60 may only be cleared, 12 follows the save only while 60 is set
            merged[12] = old_state[60] ? saved_state[12] : old_state[12];
            merged[60] = old_state[60] & saved_state[60];
         end
      end
   endgenerate

   assign new_state = merged;

endmodule

// File: rtl/msu_move_calc.sv
module msu_move_calc
   import msu_pkg::*;
#(
   parameter int unsigned XLEN = 64,
   parameter bit          WIDE = 1'b1
) (
   input  logic [XLEN-1:0] old_state,
   input  logic [XLEN-1:0] src,
   input  logic            partial,
   output logic [XLEN-1:0] new_state
);
   localparam logic [XLEN-1:0] W64_COPY =
      span(63, 61) | span(59, 35) | span(31, 16) | span(14, 13) | span(11, 6) | span(3, 1);
   localparam logic [XLEN-1:0] W32_COPY =
      span(31, 16) | span(14, 13) | span(11, 6) | span(3, 1);
   localparam logic [XLEN-1:0] PART_MASK = span(15, 15) | span(1, 1);

   logic [XLEN-1:0] full_val;
   logic [XLEN-1:0] part_val;

   assign part_val = (src & PART_MASK) | (old_state & ~PART_MASK);

   generate
      if (WIDE) begin : g_w64
         always_comb begin
            full_val = (src & W64_COPY) | (old_state & ~W64_COPY);
            full_val[TS_HI:TS_LO] = ts_pick(old_state[TS_HI:TS_LO], src[TS_HI:TS_LO]);
            full_val[5] = src[5] | src[GUARD];
            full_val[4] = src[4] | src[GUARD];
         end
      end else begin : g_w32
         always_comb begin
            full_val = (src & W32_COPY) | (old_state & ~W32_COPY);
            full_val[15] = src[15] | src[GUARD];
            full_val[5]  = src[5]  | src[GUARD];
            full_val[4]  = src[4]  | src[GUARD];
         end
      end
   endgenerate

   assign new_state = partial ? part_val : full_val;

endmodule

// File: rtl/mstate_update_unit.sv
module mstate_update_unit
   import msu_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            op_valid,
   input  logic [2:0]      op_code,
   input  logic            l_flag,
   input  logic [XLEN-1:0] gpr_src,
   input  logic [XLEN-1:0] sup_saved_state,
   input  logic [XLEN-1:0] sup_saved_addr,
   input  logic [XLEN-1:0] hyp_saved_state,
   input  logic [XLEN-1:0] hyp_saved_addr,
   input  logic            priv_mode,
   output logic [XLEN-1:0] state_out,
   output logic [XLEN-1:0] next_addr,
   output logic            addr_valid,
   output logic            priv_fault
);
   localparam int unsigned NUM_RET  = 2;
   localparam int unsigned NUM_MOVE = 2;

   generate
      if (XLEN != WORD_W) begin : g_bad_xlen
         $error("mstate_update_unit: XLEN must be 64, bit positions are fixed");
      end
      if (ALIGN_BITS < 1 || ALIGN_BITS >= XLEN) begin : g_bad_align
         $error("mstate_update_unit: ALIGN_BITS out of range");
      end
   endgenerate

   logic [XLEN-1:0] state_q;
   logic [XLEN-1:0] addr_q;
   logic            addr_vld_q;
   logic            fault_q;

   logic [XLEN-1:0] ret_state [NUM_RET];
   logic [XLEN-1:0] ret_addr  [NUM_RET];
   logic [XLEN-1:0] mov_state [NUM_MOVE];

   // index 0 = supervisor, 1 = hypervisor
   generate
      for (genvar g = 0; g < NUM_RET; g++) begin : g_ret
         msu_return_calc #(
            .XLEN      (XLEN),
            .ALIGN_BITS(ALIGN_BITS),
            .HYPER     (g == 1)
         ) u_ret (
            .old_state  (state_q),
            .saved_state((g == 1) ? hyp_saved_state : sup_saved_state),
            .saved_addr ((g == 1) ? hyp_saved_addr  : sup_saved_addr),
            .new_state  (ret_state[g]),
            .new_addr   (ret_addr[g])
         );
      end
      // index 0 = 64-bit move, 1 = 32-bit move
      for (genvar g = 0; g < NUM_MOVE; g++) begin : g_mov
         msu_move_calc #(
            .XLEN(XLEN),
            .WIDE(g == 0)
         ) u_mov (
            .old_state(state_q),
            .src      (gpr_src),
            .partial  (l_flag),
            .new_state(mov_state[g])
         );
      end
   endgenerate

   msu_op_e         op;
   logic            needs_priv;
   logic            fault_now;
   logic            is_ret;
   logic [XLEN-1:0] next_state;
   logic [XLEN-1:0] next_ret_addr;

   always_comb begin
      op            = msu_op_e'(op_code);
      needs_priv    = (op == OP_RET_SUP) || (op == OP_MOVE64) || (op == OP_MOVE32);
      fault_now     = op_valid && needs_priv && !priv_mode;
      is_ret        = 1'b0;
      next_state    = state_q;
      next_ret_addr = addr_q;
      if (op_valid && !fault_now) begin
         unique case (op)
            OP_RET_SUP: begin
               next_state    = ret_state[0];
               next_ret_addr = ret_addr[0];
               is_ret        = 1'b1;
            end
            OP_RET_HYP: begin
               next_state    = ret_state[1];
               next_ret_addr = ret_addr[1];
               is_ret        = 1'b1;
            end
            OP_MOVE64: next_state = mov_state[0];
            OP_MOVE32: next_state = mov_state[1];
            default:   next_state = state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= '0;
         addr_q     <= '0;
         addr_vld_q <= 1'b0;
         fault_q    <= 1'b0;
      end else begin
         state_q    <= next_state;
         addr_q     <= next_ret_addr;
         addr_vld_q <= is_ret;
         fault_q    <= fault_now;
      end
   end

   assign state_out  = state_q;
   assign next_addr  = addr_q;
   assign addr_valid = addr_vld_q;
   assign priv_fault = fault_q;

endmodule

// File: rtl/msu_checker.sv
module msu_checker
   import msu_pkg::*;
#(
   parameter int unsigned XLEN       = 64,
   parameter int unsigned ALIGN_BITS = 2
) (
   input logic            clk,
   input logic            rst,
   input logic            op_valid,
   input logic [2:0]      op_code,
   input logic            l_flag,
   input logic [2:0]      gpr_ts,
   input logic            gpr_guard,
   input logic            priv_mode,
   input logic [XLEN-1:0] state_out,
   input logic [XLEN-1:0] next_addr,
   input logic            addr_valid,
   input logic            priv_fault
);
   localparam logic [XLEN-1:0] ALIGN_MASK = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);
   localparam logic [XLEN-1:0] KEEP_L1    = ~(span(15, 15) | span(1, 1));

   logic is_move;
   logic guarded;
   assign is_move = (op_code == OP_MOVE64) || (op_code == OP_MOVE32);
   assign guarded = (op_code == OP_RET_SUP) || is_move;

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (state_out == '0) && !addr_valid && !priv_fault);  // R1

   AST_BIT60_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
      op_valid && op_code == OP_RET_SUP && priv_mode && !state_out[60] |=> !state_out[60]);  // R2

   AST_TS_HELD: assert property (@(posedge clk) disable iff (rst)
      op_valid && op_code == OP_MOVE64 && priv_mode && !l_flag &&
      state_out[34:32] == TS_HOLD && gpr_ts == 3'b000 |=> state_out[34:32] == TS_HOLD);  // R3

   AST_GUARD_FORCE: assert property (@(posedge clk) disable iff (rst)
      op_valid && op_code == OP_MOVE32 && priv_mode && !l_flag && gpr_guard
      |=> state_out[15] && state_out[5] && state_out[4]);  // R4

   AST_HYP_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
      op_valid && op_code == OP_RET_HYP |=> !priv_fault && addr_valid);  // R6

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      addr_valid |-> (next_addr & ALIGN_MASK) == '0);  // R7

   AST_M32_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
      op_valid && op_code == OP_MOVE32 |=> state_out[63:32] == $past(state_out[63:32]));  // R9

   AST_PARTIAL_ONLY: assert property (@(posedge clk) disable iff (rst)
      op_valid && is_move && l_flag |=> ((state_out ^ $past(state_out)) & KEEP_L1) == '0);  // R10

   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      op_valid && guarded && !priv_mode |=> priv_fault && !addr_valid && $stable(state_out));  // R11

   AST_FAULT_ADDR_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(priv_fault && addr_valid));  // R11

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(state_out) && !addr_valid && !priv_fault);  // R13

endmodule

bind mstate_update_unit msu_checker #(
   .XLEN      (XLEN),
   .ALIGN_BITS(ALIGN_BITS)
) u_msu_checker (
   .clk       (clk),
   .rst       (rst),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .l_flag    (l_flag),
   .gpr_ts    (gpr_src[34:32]),
   .gpr_guard (gpr_src[14]),
   .priv_mode (priv_mode),
   .state_out (state_out),
   .next_addr (next_addr),
   .addr_valid(addr_valid),
   .priv_fault(priv_fault)
);

// File: tb/mstate_update_unit_bench.sv
`timescale 1ns/1ps
module mstate_update_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic        l_flag = 1'b0;
   logic [63:0] gpr_src = '0;
   logic [63:0] sup_saved_state = '0;
   logic [63:0] sup_saved_addr = '0;
   logic [63:0] hyp_saved_state = '0;
   logic [63:0] hyp_saved_addr = '0;
   logic        priv_mode = 1'b1;
   logic [63:0] state_out;
   logic [63:0] next_addr;
   logic        addr_valid;
   logic        priv_fault;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [63:0] shadow = '0;

   typedef struct {
      logic [63:0] st;
      logic [63:0] ad;
      logic        av;
      logic        fl;
      string       tag;
   } exp_t;
   exp_t expq[$];

   always #4 clk = ~clk;  // 125 MHz

   mstate_update_unit u_mstate_update_unit (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .l_flag(l_flag),
      .gpr_src(gpr_src), .sup_saved_state(sup_saved_state), .sup_saved_addr(sup_saved_addr),
      .hyp_saved_state(hyp_saved_state), .hyp_saved_addr(hyp_saved_addr),
      .priv_mode(priv_mode), .state_out(state_out), .next_addr(next_addr),
      .addr_valid(addr_valid), .priv_fault(priv_fault)
   );

   task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] tsel(logic [2:0] cur, logic [2:0] s);
      if (cur == 3'b010 && s == 3'b000) return cur;
      return s;
   endfunction

   // independent reference model written bit by bit from the requirements
   function automatic logic [63:0] model(logic [63:0] o, logic [2:0] op, logic l, logic [63:0] g,
                                         logic [63:0] ss, logic [63:0] hs, logic pv,
                                         output logic flt);
      logic [63:0] n;
      n = o;
      flt = 1'b0;
      case (op)
         3'd1: if (!pv) flt = 1'b1; else begin  // R5 R2
            for (int i = 0; i < 64; i++)
               if (i >= 61 || (i >= 35 && i <= 59) || i == 31 || (i >= 22 && i <= 26) ||
                   i == 13 || i == 14 || (i >= 6 && i <= 11) || i <= 3) n[i] = ss[i];
            n[34:32] = tsel(o[34:32], ss[34:32]);
            n[15] = ss[15] | ss[14]; n[5] = ss[5] | ss[14]; n[4] = ss[4] | ss[14];
            n[12] = o[60] ? ss[12] : o[12];
            n[60] = o[60] & ss[60];
         end
         3'd2: begin  // R6
            for (int i = 0; i < 64; i++)
               if (i >= 35 || i == 31 || (i >= 22 && i <= 26) || (i >= 6 && i <= 14) || i <= 3)
                  n[i] = hs[i];
            n[34:32] = tsel(o[34:32], hs[34:32]);
            n[15] = hs[15] | hs[14]; n[5] = hs[5] | hs[14]; n[4] = hs[4] | hs[14];
         end
         3'd3: if (!pv) flt = 1'b1; else if (l) begin n[15] = g[15]; n[1] = g[1]; end else begin  // R8
            for (int i = 0; i < 64; i++)
               if (i >= 61 || (i >= 35 && i <= 59) || (i >= 16 && i <= 31) || i == 13 || i == 14 ||
                   (i >= 6 && i <= 11) || (i >= 1 && i <= 3)) n[i] = g[i];
            n[34:32] = tsel(o[34:32], g[34:32]);
            n[5] = g[5] | g[14]; n[4] = g[4] | g[14];
         end
         3'd4: if (!pv) flt = 1'b1; else if (l) begin n[15] = g[15]; n[1] = g[1]; end else begin  // R9
            for (int i = 0; i < 32; i++)
               if (i >= 16 || i == 13 || i == 14 || (i >= 6 && i <= 11) || (i >= 1 && i <= 3))
                  n[i] = g[i];
            n[15] = g[15] | g[14]; n[5] = g[5] | g[14]; n[4] = g[4] | g[14];
         end
         default: n = o;  // R12
      endcase
      return n;
   endfunction

   task automatic issue(string tag, logic [2:0] op, logic l, logic [63:0] g, logic [63:0] ss,
                        logic [63:0] sa, logic [63:0] hs, logic [63:0] ha, logic pv);
      exp_t e;
      logic f;
      @(negedge clk);
      op_code = op; l_flag = l; gpr_src = g; sup_saved_state = ss; sup_saved_addr = sa;
      hyp_saved_state = hs; hyp_saved_addr = ha; priv_mode = pv;
      e.st  = model(shadow, op, l, g, ss, hs, pv, f);
      e.fl  = f;
      e.av  = !f && (op == 3'd1 || op == 3'd2);
      e.ad  = (op == 3'd2) ? (ha & ~64'd3) : (sa & ~64'd3);
      e.tag = f ? {tag, " R11"} : tag;
      shadow = e.st;
      expq.push_back(e);
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   // scoreboard monitor: result appears on the edge that samples the strobe
   always @(posedge clk) begin
      if (!rst && op_valid) begin
         exp_t e;
         #2;
         if (expq.size() == 0) begin
            total++; bad++;
            $display("FAIL R13 actual=result expected=no pending item");
         end else begin
            e = expq.pop_front();
            check64({e.tag, " state"}, state_out, e.st);
            check64({e.tag, " R7 addr_valid"}, {63'd0, addr_valid}, {63'd0, e.av});
            check64({e.tag, " R11 priv_fault"}, {63'd0, priv_fault}, {63'd0, e.fl});
            if (e.av) check64({e.tag, " R7 next_addr"}, next_addr, e.ad);
         end
      end
   end

   task automatic idle_check(int n);
      repeat (n) @(negedge clk);
      check64("R13 idle hold", state_out, shadow);
      check64("R13 idle flags", {62'd0, addr_valid, priv_fault}, 64'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check64("R1 reset state", state_out, 64'd0);
      check64("R1 reset flags", {62'd0, addr_valid, priv_fault}, 64'd0);

      // full 64-bit move, pattern with guard bit clear
      issue("R8 move64", 3'd3, 0, 64'hA5A5_5A5A_F0F0_8F0F, 0, 0, 0, 0, 1);
      // force field to 010, then try to clear it (R3)
      issue("R8 move64 ts010", 3'd3, 0, 64'h0000_0002_0000_0000, 0, 0, 0, 0, 1);
      issue("R3 move64 keep", 3'd3, 0, 64'hFFFF_FFF8_FFFF_BFFF, 0, 0, 0, 0, 1);
      issue("R3 sup ret keep", 3'd1, 0, 0, 64'h0123_4560_89AB_CDEF, 64'h1000_0003, 0, 0, 1);
      issue("R3 hyp ret keep", 3'd2, 0, 0, 0, 0, 64'h0000_0000_0000_4000, 64'h2222_2222_2222_2227, 1);
      issue("R3 hyp ret write", 3'd2, 0, 0, 0, 0, 64'h1000_0003_0000_1000, 64'h40, 0);
      // bit 60 and bit 12 guard (R2)
      issue("R6 hyp ret set60", 3'd2, 0, 0, 0, 0, 64'hF000_0000_0000_0000, 64'h81, 1);
      issue("R2 sup ret old60 one", 3'd1, 0, 0, 64'h0000_0000_0000_1000, 64'h55, 0, 0, 1);
      issue("R2 sup ret old60 zero", 3'd1, 0, 0, 64'h1000_0000_0000_0000, 64'h66, 0, 0, 1);
      issue("R5 sup ret pattern", 3'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 1);
      issue("R5 sup ret zeros", 3'd1, 0, 0, 64'd0, 64'h8, 0, 0, 1);
      // guard bit 14 forcing (R4)
      issue("R4 move32 guard", 3'd4, 0, 64'hDEAD_BEEF_0000_4000, 0, 0, 0, 0, 1);
      issue("R4 move64 guard", 3'd3, 0, 64'h0000_0000_0000_4000, 0, 0, 0, 0, 1);
      issue("R4 sup ret guard", 3'd1, 0, 0, 64'h0000_0000_0000_4000, 64'h4, 0, 0, 1);
      issue("R9 move32 upper", 3'd4, 0, 64'hFFFF_FFFF_1234_5678, 0, 0, 0, 0, 1);
      // partial moves (R10)
      issue("R10 move64 L1", 3'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1);
      issue("R10 move32 L1", 3'd4, 1, 64'h0000_0000_0000_0000, 0, 0, 0, 0, 1);
      // privilege faults (R11)
      issue("R11 sup ret unpriv", 3'd1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7, 0, 0, 0);
      issue("R11 move64 unpriv", 3'd3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
      issue("R11 move32 unpriv", 3'd4, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
      // reads and reserved codes (R12)
      issue("R12 read", 3'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 64'hFF, 64'hFF, 64'hFF, 0);
      issue("R12 reserved", 3'd6, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF, 64'hFF, 64'hFF, 64'hFF, 1);
      idle_check(5);

      // mixed sequence
      for (int k = 0; k < 150; k++) begin
         logic [63:0] g;
         g = {$urandom, $urandom};
         if ($urandom_range(0, 3) == 0) g[34:32] = $urandom_range(0, 1) ? 3'b000 : 3'b010;
         issue("R13 mixed", 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), g,
               {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
               {$urandom, $urandom}, $urandom_range(0, 4) != 0);
      end
      idle_check(3);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule